// File: doc/BRIEF.md
# Programmable Raster Frame Timing Generator

This block paces the readout of a raster image sensor from a single pixel clock. A column counter runs across each line and a row counter steps once per line. From their values the block derives a horizontal sync, a vertical sync, a blanking indication that is inactive only inside a fixed-size active window, a row-based flash strobe, and a reset-row pointer that runs a programmable number of rows ahead of the readout row. All outputs leave through one register stage, so each pixel's counters and strobes appear together, one clock after the internal counter state.

The timing values (line length, frame height, window origin, sync end positions, flash rows and exposure) come from an external register file as pending values. A one-cycle commit request copies all of them into the active set at the next frame boundary, so no frame ever uses a mix of old and new values. The active set is visible on mirror outputs. In single-frame mode the raster parks at column 0, row 0 with every strobe inactive, and a capture request runs exactly one frame. All pins are plain control and status signals; there is no streaming interface and no back-pressure.

Top module: `sensor_frame_timer`

## Requirements
- R1: While running, the column output counts 0 to line length minus 1 on consecutive clocks; the row output advances by one when the column wraps and returns to 0 after frame height minus 1, so a frame lasts line length times frame height clocks.
- R2: Horizontal sync is active on columns 0 to hs_end minus 1 of every running line; vertical sync is active on rows 0 to vs_end minus 1 of every running frame.
- R3: Blank is inactive exactly on the WIN_W columns starting at the window column origin within the WIN_H rows starting at the window row origin, and active everywhere else.
- R4: The flash strobe is active on every pixel of rows flash_on up to flash_off minus 1 and inactive elsewhere; flash_off not above flash_on gives no flash at all.
- R5: pol_i applies live to the outputs: bit 0 horizontal sync, bit 1 vertical sync, bit 2 blank, bit 3 flash; a 1 makes that output active high, a 0 active low.
- R6: The reset-row output equals (row + E) modulo frame height, where E is the exposure value clamped to 1 when it is 0 and to frame height minus 1 when it is frame height or more; row_start_o marks column 0 of every running line.
- R7: A commit request raises commit_busy_o on the next clock while the raster runs; the active set and mirrors keep their old values until the frame boundary, where all pending values load together, busy clears, and the first pixel of the following frame uses the new set.
- R8: After reset the mirrors show the parameter defaults, and commit_busy_o and capture_busy_o are 0.
- R9: With single_mode_i high, the raster stops at the end of the current frame and stays at column 0, row 0 with sync and flash inactive and blank active.
- R10: A capture request while stopped in single-frame mode runs exactly one frame; capture_busy_o is 1 from its first pixel through its last pixel and 0 afterwards.
- R11: A capture request is ignored while a frame is running or when single_mode_i is low: no extra frame runs and capture_busy_o does not rise.
- R12: A commit request while the raster is stopped loads the pending set on that same clock edge, so the mirrors change and busy stays 0.
- R13: Lowering single_mode_i while stopped restarts free-running frames on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nxt_line_len_i | input | COL_W | Pending line length in clocks |
| nxt_frame_h_i | input | ROW_W | Pending frame height in rows |
| nxt_col_begin_i | input | COL_W | Pending window column origin |
| nxt_row_begin_i | input | ROW_W | Pending window row origin |
| nxt_hs_end_i | input | COL_W | Pending horizontal sync end column |
| nxt_vs_end_i | input | ROW_W | Pending vertical sync end row |
| nxt_flash_on_i | input | ROW_W | Pending first flash row |
| nxt_flash_off_i | input | ROW_W | Pending row where flash stops |
| nxt_expo_i | input | ROW_W | Pending exposure in rows |
| commit_req_i | input | 1 | One-cycle request to load the pending set |
| commit_busy_o | output | 1 | Commit requested, not yet applied |
| pol_i | input | 4 | Output polarity bits |
| single_mode_i | input | 1 | Single-frame mode |
| capture_i | input | 1 | One-cycle capture request |
| capture_busy_o | output | 1 | Captured frame in progress |
| col_o | output | COL_W | Column of the current pixel |
| row_o | output | ROW_W | Row of the current pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Blanking, inactive inside the window |
| flash_o | output | 1 | Flash strobe |
| rst_row_o | output | ROW_W | Row whose exposure starts now |
| row_start_o | output | 1 | Column 0 of a running line |
| act_line_len_o | output | COL_W | Active line length |
| act_frame_h_o | output | ROW_W | Active frame height |
| act_col_begin_o | output | COL_W | Active window column origin |
| act_row_begin_o | output | ROW_W | Active window row origin |
| act_hs_end_o | output | COL_W | Active horizontal sync end |
| act_vs_end_o | output | ROW_W | Active vertical sync end |

## Verification
Five timing sets are committed in turn and each is measured over one whole frame, counting the active-level clocks of every strobe against closed-form totals; the sets differ in polarity word, window position, sync widths of zero and near the line length, an empty and a full flash window, and exposures of 0, 1, the maximum and above the frame height, so a wrong comparison bound, a swapped polarity bit or a missing clamp shows as a count or pointer mismatch. Directed runs then park the raster in single-frame mode, commit while parked, capture one frame with a second capture thrown in mid-frame, and leave single-frame mode, which separates a raster that stops and restarts at the right edge from one that runs on or misses a frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_FREE = 2'd1,
    RUN_SHOT = 2'd2
  } run_state_e;

  localparam int POL_W     = 4;
  localparam int POL_HS    = 0;
  localparam int POL_VS    = 1;
  localparam int POL_BLANK = 2;
  localparam int POL_FLASH = 3;

endpackage

// File: rtl/sft_shadow.sv
module sft_shadow #(
  parameter int COL_W          = 10,
  parameter int ROW_W          = 16,
  parameter int DEF_LINE_LEN   = 500,
  parameter int DEF_FRAME_H    = 400,
  parameter int DEF_COL_BEGIN  = 100,
  parameter int DEF_ROW_BEGIN  = 10,
  parameter int DEF_HS_END     = 64,
  parameter int DEF_VS_END     = 3,
  parameter int DEF_FLASH_ON   = 298,
  parameter int DEF_FLASH_OFF  = 318,
  parameter int DEF_EXPO       = 399
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] nxt_line_len_i,
  input  logic [ROW_W-1:0] nxt_frame_h_i,
  input  logic [COL_W-1:0] nxt_col_begin_i,
  input  logic [ROW_W-1:0] nxt_row_begin_i,
  input  logic [COL_W-1:0] nxt_hs_end_i,
  input  logic [ROW_W-1:0] nxt_vs_end_i,
  input  logic [ROW_W-1:0] nxt_flash_on_i,
  input  logic [ROW_W-1:0] nxt_flash_off_i,
  input  logic [ROW_W-1:0] nxt_expo_i,
  input  logic             commit_req_i,
  input  logic             boundary_i,
  output logic [COL_W-1:0] act_line_len_o,
  output logic [ROW_W-1:0] act_frame_h_o,
  output logic [COL_W-1:0] act_col_begin_o,
  output logic [ROW_W-1:0] act_row_begin_o,
  output logic [COL_W-1:0] act_hs_end_o,
  output logic [ROW_W-1:0] act_vs_end_o,
  output logic [ROW_W-1:0] act_flash_on_o,
  output logic [ROW_W-1:0] act_flash_off_o,
  output logic [ROW_W-1:0] act_expo_o,
  output logic             commit_busy_o
);

  logic pend_q;
  logic load;

  assign load          = boundary_i && (pend_q || commit_req_i);
  assign commit_busy_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_line_len_o  <= COL_W'(DEF_LINE_LEN);
      act_frame_h_o   <= ROW_W'(DEF_FRAME_H);
      act_col_begin_o <= COL_W'(DEF_COL_BEGIN);
      act_row_begin_o <= ROW_W'(DEF_ROW_BEGIN);
      act_hs_end_o    <= COL_W'(DEF_HS_END);
      act_vs_end_o    <= ROW_W'(DEF_VS_END);
      act_flash_on_o  <= ROW_W'(DEF_FLASH_ON);
      act_flash_off_o <= ROW_W'(DEF_FLASH_OFF);
      act_expo_o      <= ROW_W'(DEF_EXPO);
      pend_q          <= 1'b0;
    end else if (load) begin
      act_line_len_o  <= nxt_line_len_i;
      act_frame_h_o   <= nxt_frame_h_i;
      act_col_begin_o <= nxt_col_begin_i;
      act_row_begin_o <= nxt_row_begin_i;
      act_hs_end_o    <= nxt_hs_end_i;
      act_vs_end_o    <= nxt_vs_end_i;
      act_flash_on_o  <= nxt_flash_on_i;
      act_flash_off_o <= nxt_flash_off_i;
      act_expo_o      <= nxt_expo_i;
      pend_q          <= 1'b0;
    end else if (commit_req_i) begin
      pend_q <= 1'b1;
    end
  end

  AST_ACT_HELD_OFF_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> ($stable(act_line_len_o) && $stable(act_frame_h_o) &&
                     $stable(act_col_begin_o) && $stable(act_expo_o)))
    else $error("active set changed away from a frame boundary"); // R7

  AST_BUSY_CLEARS_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && boundary_i) |=> !pend_q)
    else $error("commit busy survived a frame boundary"); // R7

endmodule

// File: rtl/sft_raster.sv
module sft_raster
  import sft_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] line_len_i,
  input  logic [ROW_W-1:0] frame_h_i,
  input  logic             single_mode_i,
  input  logic             capture_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output run_state_e       state_o,
  output logic             boundary_o
);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  run_state_e       state_q, state_d;
  logic             running, col_last, row_last, wrap;

  assign running    = (state_q != RUN_IDLE);
  assign col_last   = (col_q == line_len_i - COL_W'(1));
  assign row_last   = (row_q == frame_h_i - ROW_W'(1));
  assign wrap       = running && col_last && row_last;
  assign boundary_o = wrap || !running;
  assign col_o      = col_q;
  assign row_o      = row_q;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RUN_IDLE: begin
        if (!single_mode_i)  state_d = RUN_FREE;
        else if (capture_i)  state_d = RUN_SHOT;
      end
      RUN_FREE, RUN_SHOT: begin
        if (wrap) state_d = single_mode_i ? RUN_IDLE : RUN_FREE;
      end
      default: state_d = RUN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
      col_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      if (running) begin
        if (col_last) begin
          col_q <= '0;
          row_q <= row_last ? '0 : row_q + ROW_W'(1);
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  AST_COL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> (col_q < line_len_i))
    else $error("column beyond line length"); // R1

  AST_ROW_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && col_last && !row_last) |=> (row_q == $past(row_q) + ROW_W'(1)))
    else $error("row did not advance at line end"); // R1

  AST_IDLE_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RUN_IDLE) |-> (col_q == '0 && row_q == '0))
    else $error("stopped raster not parked at origin"); // R9

  AST_SHOT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RUN_SHOT && wrap) |=> (state_q != RUN_SHOT))
    else $error("captured frame ran past its end"); // R10

endmodule

// File: rtl/sft_strobes.sv
module sft_strobes
  import sft_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 16,
  parameter int WIN_W = 352,
  parameter int WIN_H = 298
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  run_state_e       state_i,
  input  logic [ROW_W-1:0] frame_h_i,
  input  logic [COL_W-1:0] col_begin_i,
  input  logic [ROW_W-1:0] row_begin_i,
  input  logic [COL_W-1:0] hs_end_i,
  input  logic [ROW_W-1:0] vs_end_i,
  input  logic [ROW_W-1:0] flash_on_i,
  input  logic [ROW_W-1:0] flash_off_i,
  input  logic [ROW_W-1:0] expo_i,
  input  logic [POL_W-1:0] pol_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             blank_o,
  output logic             flash_o,
  output logic [ROW_W-1:0] rst_row_o,
  output logic             row_start_o,
  output logic             capture_busy_o
);

  localparam int CW1 = COL_W + 1;
  localparam int RW1 = ROW_W + 1;

  logic             run;
  logic             in_col, in_row;
  logic [CW1-1:0]   col_hi;
  logic [RW1-1:0]   row_hi;
  logic [ROW_W-1:0] eff_expo;
  logic [RW1-1:0]   ahead;
  logic [ROW_W-1:0] rst_row_d;
  logic [POL_W-1:0] act_lvl;

  assign run    = (state_i != RUN_IDLE);
  assign col_hi = {1'b0, col_begin_i} + CW1'(WIN_W);
  assign row_hi = {1'b0, row_begin_i} + RW1'(WIN_H);
  assign in_col = (col_i >= col_begin_i) && ({1'b0, col_i} < col_hi);
  assign in_row = (row_i >= row_begin_i) && ({1'b0, row_i} < row_hi);

  always_comb begin
    if (expo_i == '0)              eff_expo = ROW_W'(1);
    else if (expo_i >= frame_h_i)  eff_expo = frame_h_i - ROW_W'(1);
    else                           eff_expo = expo_i;
  end

  assign ahead     = {1'b0, row_i} + {1'b0, eff_expo};
  assign rst_row_d = (ahead >= {1'b0, frame_h_i}) ? ROW_W'(ahead - {1'b0, frame_h_i})
                                                  : ahead[ROW_W-1:0];

  always_comb begin
    act_lvl            = '0;
    act_lvl[POL_HS]    = run && (col_i < hs_end_i);
    act_lvl[POL_VS]    = run && (row_i < vs_end_i);
    act_lvl[POL_BLANK] = !(run && in_col && in_row);
    act_lvl[POL_FLASH] = run && (row_i >= flash_on_i) && (row_i < flash_off_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o          <= '0;
      row_o          <= '0;
      hsync_o        <= 1'b0;
      vsync_o        <= 1'b0;
      blank_o        <= 1'b0;
      flash_o        <= 1'b0;
      rst_row_o      <= '0;
      row_start_o    <= 1'b0;
      capture_busy_o <= 1'b0;
    end else begin
      col_o          <= col_i;
      row_o          <= row_i;
      hsync_o        <= ~(act_lvl[POL_HS]    ^ pol_i[POL_HS]);
      vsync_o        <= ~(act_lvl[POL_VS]    ^ pol_i[POL_VS]);
      blank_o        <= ~(act_lvl[POL_BLANK] ^ pol_i[POL_BLANK]);
      flash_o        <= ~(act_lvl[POL_FLASH] ^ pol_i[POL_FLASH]);
      rst_row_o      <= rst_row_d;
      row_start_o    <= run && (col_i == '0);
      capture_busy_o <= (state_i == RUN_SHOT);
    end
  end

  AST_RESET_ROW_AHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (rst_row_o != row_o))
    else $error("reset row coincides with readout row"); // R6

  AST_RESET_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (rst_row_o < $past(frame_h_i)))
    else $error("reset row outside the frame"); // R6

endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
  import sft_pkg::*;
#(
  parameter int COL_W          = 10,
  parameter int ROW_W          = 16,
  parameter int WIN_W          = 352,
  parameter int WIN_H          = 298,
  parameter int DEF_LINE_LEN   = 500,
  parameter int DEF_FRAME_H    = 400,
  parameter int DEF_COL_BEGIN  = 100,
  parameter int DEF_ROW_BEGIN  = 10,
  parameter int DEF_HS_END     = 64,
  parameter int DEF_VS_END     = 3,
  parameter int DEF_FLASH_ON   = 298,
  parameter int DEF_FLASH_OFF  = 318,
  parameter int DEF_EXPO       = 399
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] nxt_line_len_i,
  input  logic [ROW_W-1:0] nxt_frame_h_i,
  input  logic [COL_W-1:0] nxt_col_begin_i,
  input  logic [ROW_W-1:0] nxt_row_begin_i,
  input  logic [COL_W-1:0] nxt_hs_end_i,
  input  logic [ROW_W-1:0] nxt_vs_end_i,
  input  logic [ROW_W-1:0] nxt_flash_on_i,
  input  logic [ROW_W-1:0] nxt_flash_off_i,
  input  logic [ROW_W-1:0] nxt_expo_i,
  input  logic             commit_req_i,
  output logic             commit_busy_o,
  input  logic [3:0]       pol_i,
  input  logic             single_mode_i,
  input  logic             capture_i,
  output logic             capture_busy_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             blank_o,
  output logic             flash_o,
  output logic [ROW_W-1:0] rst_row_o,
  output logic             row_start_o,
  output logic [COL_W-1:0] act_line_len_o,
  output logic [ROW_W-1:0] act_frame_h_o,
  output logic [COL_W-1:0] act_col_begin_o,
  output logic [ROW_W-1:0] act_row_begin_o,
  output logic [COL_W-1:0] act_hs_end_o,
  output logic [ROW_W-1:0] act_vs_end_o
);

  logic [ROW_W-1:0] act_flash_on, act_flash_off, act_expo;
  logic [COL_W-1:0] cnt_col;
  logic [ROW_W-1:0] cnt_row;
  run_state_e       run_state;
  logic             boundary;

  sft_shadow #(
    .COL_W(COL_W), .ROW_W(ROW_W),
    .DEF_LINE_LEN(DEF_LINE_LEN), .DEF_FRAME_H(DEF_FRAME_H),
    .DEF_COL_BEGIN(DEF_COL_BEGIN), .DEF_ROW_BEGIN(DEF_ROW_BEGIN),
    .DEF_HS_END(DEF_HS_END), .DEF_VS_END(DEF_VS_END),
    .DEF_FLASH_ON(DEF_FLASH_ON), .DEF_FLASH_OFF(DEF_FLASH_OFF),
    .DEF_EXPO(DEF_EXPO)
  ) u_shadow (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .nxt_line_len_i  (nxt_line_len_i),
    .nxt_frame_h_i   (nxt_frame_h_i),
    .nxt_col_begin_i (nxt_col_begin_i),
    .nxt_row_begin_i (nxt_row_begin_i),
    .nxt_hs_end_i    (nxt_hs_end_i),
    .nxt_vs_end_i    (nxt_vs_end_i),
    .nxt_flash_on_i  (nxt_flash_on_i),
    .nxt_flash_off_i (nxt_flash_off_i),
    .nxt_expo_i      (nxt_expo_i),
    .commit_req_i    (commit_req_i),
    .boundary_i      (boundary),
    .act_line_len_o  (act_line_len_o),
    .act_frame_h_o   (act_frame_h_o),
    .act_col_begin_o (act_col_begin_o),
    .act_row_begin_o (act_row_begin_o),
    .act_hs_end_o    (act_hs_end_o),
    .act_vs_end_o    (act_vs_end_o),
    .act_flash_on_o  (act_flash_on),
    .act_flash_off_o (act_flash_off),
    .act_expo_o      (act_expo),
    .commit_busy_o   (commit_busy_o)
  );

  sft_raster #(.COL_W(COL_W), .ROW_W(ROW_W)) u_raster (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_len_i    (act_line_len_o),
    .frame_h_i     (act_frame_h_o),
    .single_mode_i (single_mode_i),
    .capture_i     (capture_i),
    .col_o         (cnt_col),
    .row_o         (cnt_row),
    .state_o       (run_state),
    .boundary_o    (boundary)
  );

  sft_strobes #(.COL_W(COL_W), .ROW_W(ROW_W), .WIN_W(WIN_W), .WIN_H(WIN_H)) u_strobes (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .col_i          (cnt_col),
    .row_i          (cnt_row),
    .state_i        (run_state),
    .frame_h_i      (act_frame_h_o),
    .col_begin_i    (act_col_begin_o),
    .row_begin_i    (act_row_begin_o),
    .hs_end_i       (act_hs_end_o),
    .vs_end_i       (act_vs_end_o),
    .flash_on_i     (act_flash_on),
    .flash_off_i    (act_flash_off),
    .expo_i         (act_expo),
    .pol_i          (pol_i),
    .col_o          (col_o),
    .row_o          (row_o),
    .hsync_o        (hsync_o),
    .vsync_o        (vsync_o),
    .blank_o        (blank_o),
    .flash_o        (flash_o),
    .rst_row_o      (rst_row_o),
    .row_start_o    (row_start_o),
    .capture_busy_o (capture_busy_o)
  );

endmodule

// File: tb/sensor_frame_timer_bench.sv
`timescale 1ns/1ps
module sensor_frame_timer_bench;

  localparam int CW = 10;
  localparam int RW = 16;
  localparam int WW = 6;
  localparam int WH = 4;

  typedef struct packed {
    logic [15:0] len, h, cb, rb, hse, vse, fon, foff, expo;
    logic [3:0]  pol;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd16, 16'd10, 16'd5,  16'd2, 16'd3,  16'd1, 16'd6, 16'd8, 16'd9,  4'hF},
    '{16'd20, 16'd12, 16'd8,  16'd4, 16'd5,  16'd2, 16'd0, 16'd3, 16'd1,  4'h0},
    '{16'd12, 16'd8,  16'd2,  16'd3, 16'd1,  16'd3, 16'd5, 16'd5, 16'd0,  4'hA},
    '{16'd24, 16'd9,  16'd18, 16'd5, 16'd23, 16'd8, 16'd7, 16'd9, 16'd30, 4'h5},
    '{16'd10, 16'd6,  16'd4,  16'd0, 16'd0,  16'd0, 16'd0, 16'd6, 16'd3,  4'h3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] nxt_len = '0, nxt_cb = '0, nxt_hse = '0;
  logic [RW-1:0] nxt_h = '0, nxt_rb = '0, nxt_vse = '0, nxt_fon = '0, nxt_foff = '0, nxt_expo = '0;
  logic commit = 1'b0, single = 1'b0, capture = 1'b0;
  logic [3:0] pol = 4'hF;
  logic commit_busy, capture_busy, hsync, vsync, blank, flash, row_start;
  logic [CW-1:0] col, m_len, m_cb, m_hse;
  logic [RW-1:0] row, rst_row, m_h, m_rb, m_vse;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sensor_frame_timer #(
    .COL_W(CW), .ROW_W(RW), .WIN_W(WW), .WIN_H(WH),
    .DEF_LINE_LEN(16), .DEF_FRAME_H(10), .DEF_COL_BEGIN(5), .DEF_ROW_BEGIN(2),
    .DEF_HS_END(3), .DEF_VS_END(1), .DEF_FLASH_ON(6), .DEF_FLASH_OFF(8), .DEF_EXPO(9)
  ) u_sensor_frame_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .nxt_line_len_i(nxt_len), .nxt_frame_h_i(nxt_h), .nxt_col_begin_i(nxt_cb),
    .nxt_row_begin_i(nxt_rb), .nxt_hs_end_i(nxt_hse), .nxt_vs_end_i(nxt_vse),
    .nxt_flash_on_i(nxt_fon), .nxt_flash_off_i(nxt_foff), .nxt_expo_i(nxt_expo),
    .commit_req_i(commit), .commit_busy_o(commit_busy), .pol_i(pol),
    .single_mode_i(single), .capture_i(capture), .capture_busy_o(capture_busy),
    .col_o(col), .row_o(row), .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank),
    .flash_o(flash), .rst_row_o(rst_row), .row_start_o(row_start),
    .act_line_len_o(m_len), .act_frame_h_o(m_h), .act_col_begin_o(m_cb),
    .act_row_begin_o(m_rb), .act_hs_end_o(m_hse), .act_vs_end_o(m_vse)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive_cfg(input vec_t v);
    nxt_len  = v.len[CW-1:0];  nxt_h   = v.h;   nxt_cb   = v.cb[CW-1:0];
    nxt_rb   = v.rb;           nxt_hse = v.hse[CW-1:0]; nxt_vse = v.vse;
    nxt_fon  = v.fon;          nxt_foff = v.foff; nxt_expo = v.expo;
    pol      = v.pol;
  endtask

  task automatic pulse_commit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  function automatic int eff_expo(input vec_t v);
    if (v.expo == 0) return 1;
    if (v.expo >= v.h) return int'(v.h) - 1;
    return int'(v.expo);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int prev_len;
    prev_len = 16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(commit_busy == 1'b0, "R8 commit busy after reset", commit_busy, 0);
    chk(capture_busy == 1'b0, "R8 capture busy after reset", capture_busy, 0);
    chk(m_len == 16 && m_h == 10, "R8 default line/frame mirror", m_len, 16);
    chk(m_cb == 5 && m_rb == 2, "R8 default window origin mirror", m_cb, 5);
    chk(m_hse == 3 && m_vse == 1, "R8 default sync end mirror", m_hse, 3);

    // Vector table: commit a set, then measure one whole frame
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      int L, H, n, tmo, bad_pos, bad_rr, bad_rs, hs_c, vs_c, bl_c, fl_c;
      int hs_e, vs_e, fl_e, lo, hi, E;
      v = VECS[k];
      L = int'(v.len); H = int'(v.h); E = eff_expo(v);
      drive_cfg(v);
      pulse_commit();
      chk(commit_busy == 1'b1, $sformatf("R7 busy after commit v%0d", k), commit_busy, 1);
      chk(int'(m_len) == prev_len, $sformatf("R7 mirror held before boundary v%0d", k), m_len, prev_len);
      tmo = 0;
      while (commit_busy && tmo < 5000) begin @(negedge clk); tmo++; end
      chk(!commit_busy, $sformatf("R7 busy cleared v%0d", k), commit_busy, 0);
      chk(int'(m_len) == L && int'(m_h) == H && int'(m_cb) == int'(v.cb) &&
          int'(m_rb) == int'(v.rb) && int'(m_hse) == int'(v.hse) && int'(m_vse) == int'(v.vse),
          $sformatf("R8 mirrors after commit v%0d", k), m_len, L);
      tmo = 0;
      while (!(col == 0 && row == 0) && tmo < 5000) begin @(negedge clk); tmo++; end
      bad_pos = 0; bad_rr = 0; bad_rs = 0; hs_c = 0; vs_c = 0; bl_c = 0; fl_c = 0;
      for (int i = 0; i < L * H; i++) begin
        if (int'(col) != i % L || int'(row) != i / L) bad_pos++;
        if (int'(rst_row) != (int'(row) + E) % H) bad_rr++;
        if (row_start != (col == 0)) bad_rs++;
        if (hsync == pol[0]) hs_c++;
        if (vsync == pol[1]) vs_c++;
        if (blank == pol[2]) bl_c++;
        if (flash == pol[3]) fl_c++;
        @(negedge clk);
      end
      hs_e = (int'(v.hse) < L ? int'(v.hse) : L) * H;
      vs_e = (int'(v.vse) < H ? int'(v.vse) : H) * L;
      lo = int'(v.fon);
      hi = int'(v.foff) < H ? int'(v.foff) : H;
      fl_e = (hi > lo) ? (hi - lo) * L : 0;
      chk(bad_pos == 0, $sformatf("R1 raster sequence v%0d", k), bad_pos, 0);
      chk(int'(col) == 0 && int'(row) == 0, $sformatf("R1 frame length v%0d", k), col, 0);
      chk(hs_c == hs_e, $sformatf("R2 R5 hsync active clocks v%0d", k), hs_c, hs_e);
      chk(vs_c == vs_e, $sformatf("R2 R5 vsync active clocks v%0d", k), vs_c, vs_e);
      chk(bl_c == L * H - WW * WH, $sformatf("R3 R5 blank active clocks v%0d", k), bl_c, L * H - WW * WH);
      chk(fl_c == fl_e, $sformatf("R4 R5 flash active clocks v%0d", k), fl_c, fl_e);
      chk(bad_rr == 0, $sformatf("R6 reset row pointer v%0d", k), bad_rr, 0);
      chk(bad_rs == 0, $sformatf("R6 row start marker v%0d", k), bad_rs, 0);
      prev_len = L;
    end

    // Directed: single-frame mode parks the raster (active set is the last vector)
    single = 1'b1;
    repeat (125) @(negedge clk);
    chk(col == 0 && row == 0, "R9 parked at origin", col, 0);
    chk(flash == ~pol[3], "R9 flash inactive while parked", flash, ~pol[3]);
    chk(blank == pol[2], "R9 blank active while parked", blank, pol[2]);
    chk(capture_busy == 1'b0, "R9 no capture busy while parked", capture_busy, 0);
    begin
      int moved;
      moved = 0;
      for (int i = 0; i < 20; i++) begin
        if (col != 0 || row != 0 || flash != ~pol[3]) moved++;
        @(negedge clk);
      end
      chk(moved == 0, "R9 stays parked", moved, 0);
    end

    // R12: commit while stopped applies at once
    nxt_len = 10'd14;
    pulse_commit();
    chk(commit_busy == 1'b0, "R12 busy stays low when stopped", commit_busy, 0);
    chk(int'(m_len) == 14, "R12 mirror updated at once", m_len, 14);

    // R10 / R11: one captured frame, second capture mid-frame ignored
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    @(negedge clk);
    chk(capture_busy == 1'b1 && col == 0 && row == 0, "R10 capture starts at origin", capture_busy, 1);
    begin
      int n;
      n = 0;
      while (capture_busy && n < 1000) begin
        n++;
        capture = (n == 10);
        @(negedge clk);
      end
      capture = 1'b0;
      chk(n == 14 * 6, "R10 captured frame length", n, 84);
    end
    begin
      int moved;
      moved = 0;
      for (int i = 0; i < 30; i++) begin
        if (capture_busy || col != 0 || row != 0) moved++;
        @(negedge clk);
      end
      chk(moved == 0, "R11 capture during a frame ignored", moved, 0);
    end

    // R13: leaving single-frame mode restarts free running
    single = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(int'(col) == 1 && int'(row) == 0, "R13 free running restarts", col, 1);
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 5; i++) begin
        if (capture_busy) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R11 capture ignored in normal mode", seen, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule